// File: doc/BRIEF.md
# Streaming XOR Payload Cipher

This block sits in a 256-bit valid/ready packet stream and scrambles the layer-3 payload of every frame by XORing it with a fixed 32-bit key. The Ethernet header and a 20-byte IPv4 header (no options) are left alone, so a scrambled frame can still be switched and routed. XOR is its own inverse, so the same block, with the same key, restores the original payload at the far end.

Each 32-byte beat carries 128 bits of sideband metadata, a per-byte strobe and an end-of-frame flag. All three pass through untouched. Incoming beats enter a four-entry fall-through queue. The output side presents the head of that queue, with the key applied according to where the beat sits in its frame. The output valid is driven only by queue occupancy and never looks at the output ready. The input ready is high whenever the queue has a free slot. A beat moves on a port only in a cycle where both valid and ready on that port are high, and a stalled output holds its data until it is taken.

Top module: `xor_payload_cipher`

## Requirements
- R1: The first beat of every frame (frame bytes 1 to 32) leaves with its data unchanged.
- R2: On the second beat, beat bytes 0 and 1 (frame bytes 33 and 34) are unchanged. Every valid byte at beat offset i from 2 to 31 is XORed with key bits [8*(i mod 4)+7 : 8*(i mod 4)].
- R3: On the third and later beats of a frame, every valid byte at beat offset i is XORed with key bits [8*(i mod 4)+7 : 8*(i mod 4)]. Byte i sits at data bits [8i+7 : 8i].
- R4: A byte whose strobe bit is 0 leaves unchanged, whatever its position.
- R5: Metadata, strobe and end-of-frame flag leave exactly as they entered, with beats in arrival order.
- R6: The beat after an end-of-frame beat is treated as the first beat of a new frame. This also holds after one-beat frames and after frames that end on their second beat.
- R7: Sending a frame's output through the block a second time yields the original data.
- R8: While the output valid is high and the output ready is low, the output valid stays high and the output data stays unchanged.
- R9: With the output stalled, exactly four beats are accepted and the input ready then drops. No beat is lost or reordered.
- R10: During reset the output valid is low and the input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 256 | Inbound beat data, byte i at bits [8i+7:8i] |
| s_tstrb | input | 32 | Inbound byte valid flags |
| s_tuser | input | 128 | Inbound metadata |
| s_tlast | input | 1 | Inbound end-of-frame flag |
| s_tvalid | input | 1 | Inbound beat valid |
| s_tready | output | 1 | Block can accept a beat |
| m_tdata | output | 256 | Outbound beat data |
| m_tstrb | output | 32 | Outbound byte valid flags |
| m_tuser | output | 128 | Outbound metadata |
| m_tlast | output | 1 | Outbound end-of-frame flag |
| m_tvalid | output | 1 | Outbound beat valid |
| m_tready | input | 1 | Downstream accepts the beat |

## Verification
The hardest case to reach from the ports is a frame boundary that crosses the queue while the position tracker is mid-frame. This happens when the end-of-frame beat of a short frame is consumed in the same cycle that the next frame's first beat is waiting at the head. The stimulus covers it with back-to-back one-beat and two-beat frames at full throughput, and with long random runs in which both valids and readies are throttled. A directed stall holds the output ready low until the queue is full, so the bench can watch the input ready fall after the fourth beat. A round trip feeds captured output back in to confirm that the payload is restored.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
  // Where the head beat sits inside its frame.
  typedef enum logic [1:0] {
    POS_HDR  = 2'd0,  // first beat, header only
    POS_EDGE = 2'd1,  // header tail followed by payload
    POS_BODY = 2'd2   // payload only
  } beat_pos_e;
endpackage

// File: rtl/xpc_fifo.sv
module xpc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      count;
  logic             push, pop;

  assign in_ready  = (count != FULL_CNT);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_CNT) && !pop |=> (count == FULL_CNT) && !in_ready);
endmodule

// File: rtl/xpc_mask_gen.sv
module xpc_mask_gen
  import xpc_pkg::*;
#(
  parameter int          BYTES     = 32,
  parameter int          HDR_BYTES = 34,
  parameter int          KEY_W     = 32,
  parameter logic [31:0] KEY       = 32'hA5C3_1E77
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               end_pkt,
  input  logic [BYTES-1:0]   strb,
  output logic [8*BYTES-1:0] mask
);
  // Header bytes that spill into the second beat.
  localparam int CUT       = HDR_BYTES - BYTES;
  localparam int KEY_BYTES = KEY_W / 8;

  beat_pos_e       pos, pos_nxt;
  logic [BYTES-1:0] en;

  always_comb begin
    pos_nxt = pos;
    if (advance) begin
      if (end_pkt) pos_nxt = POS_HDR;
      else begin
        case (pos)
          POS_HDR:  pos_nxt = POS_EDGE;
          POS_EDGE: pos_nxt = POS_BODY;
          default:  pos_nxt = POS_BODY;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pos <= POS_HDR;
    else        pos <= pos_nxt;
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    localparam int KB      = i % KEY_BYTES;
    localparam bit PAST_HD = (i >= CUT);
    assign en[i] = strb[i] && ((pos == POS_BODY) || ((pos == POS_EDGE) && PAST_HD));
    assign mask[8*i +: 8] = en[i] ? KEY[8*KB +: 8] : 8'h00;
  end

  assert_hdr_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == POS_HDR) |-> (mask == '0));
  assert_eop_rewind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance && end_pkt |=> (pos == POS_HDR));
  if (CUT > 0) begin : g_cut_chk
    assert_edge_cut_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == POS_EDGE) |-> (mask[8*CUT-1:0] == '0));
  end
endmodule

// File: rtl/xor_payload_cipher.sv
module xor_payload_cipher #(
  parameter int          DATA_W    = 256,
  parameter int          USER_W    = 128,
  parameter int          FIFO_D    = 4,
  parameter int          HDR_BYTES = 34,
  parameter logic [31:0] KEY       = 32'hA5C3_1E77
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     s_tdata,
  input  logic [DATA_W/8-1:0]   s_tstrb,
  input  logic [USER_W-1:0]     s_tuser,
  input  logic                  s_tlast,
  input  logic                  s_tvalid,
  output logic                  s_tready,
  output logic [DATA_W-1:0]     m_tdata,
  output logic [DATA_W/8-1:0]   m_tstrb,
  output logic [USER_W-1:0]     m_tuser,
  output logic                  m_tlast,
  output logic                  m_tvalid,
  input  logic                  m_tready
);
  localparam int BYTES = DATA_W / 8;
  localparam int FW    = DATA_W + BYTES + USER_W + 1;

  logic [FW-1:0]     q_in, q_out;
  logic [DATA_W-1:0] head_data, mask;
  logic              advance;

  assign q_in = {s_tlast, s_tuser, s_tstrb, s_tdata};

  xpc_fifo #(.WIDTH(FW), .DEPTH(FIFO_D)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_tvalid),
    .in_ready  (s_tready),
    .in_data   (q_in),
    .out_valid (m_tvalid),
    .out_ready (m_tready),
    .out_data  (q_out)
  );

  assign {m_tlast, m_tuser, m_tstrb, head_data} = q_out;
  assign advance = m_tvalid && m_tready;

  xpc_mask_gen #(
    .BYTES(BYTES), .HDR_BYTES(HDR_BYTES), .KEY_W(32), .KEY(KEY)
  ) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .end_pkt (m_tlast),
    .strb    (m_tstrb),
    .mask    (mask)
  );

  assign m_tdata = head_data ^ mask;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast)
                              && $stable(m_tuser) && $stable(m_tstrb));
endmodule

// File: tb/sim_xor_payload_cipher.sv
module sim_xor_payload_cipher;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] TB_KEY     = 32'hA5C3_1E77;
  localparam int          MAXB       = 512;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] s_tdata, m_tdata;
  logic [31:0]  s_tstrb, m_tstrb;
  logic [127:0] s_tuser, m_tuser;
  logic         s_tlast, s_tvalid, s_tready, m_tlast, m_tvalid, m_tready;

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_payload_cipher u0 (
    .clk(clk), .rst_n(rst_n),
    .s_tdata(s_tdata), .s_tstrb(s_tstrb), .s_tuser(s_tuser), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tstrb(m_tstrb), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  logic [255:0] st_d [MAXB];
  logic [31:0]  st_s [MAXB];
  logic [127:0] st_u [MAXB];
  logic         st_l [MAXB];
  logic [255:0] cap_d [MAXB];
  logic [255:0] org_d [MAXB];
  int nst;
  int nvec = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act,
                     input logic [255:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [255:0] exp_data(input logic [255:0] d, input logic [31:0] s,
                                            input int pos);
    logic [255:0] r = d;
    for (int i = 0; i < 32; i++)
      if ((pos * 32 + i) >= 34 && s[i]) r[8*i +: 8] = d[8*i +: 8] ^ TB_KEY[8*(i%4) +: 8];
    return r;
  endfunction

  // Append a frame of len beats; last beat holds nbytes valid bytes.
  task automatic add_pkt(input int len, input int nbytes);
    for (int b = 0; b < len; b++) begin
      st_d[nst] = rnd256();
      st_u[nst] = {$urandom, $urandom, $urandom, $urandom};
      st_l[nst] = (b == len - 1);
      st_s[nst] = (b == len - 1 && nbytes < 32) ? ((32'd1 << nbytes) - 32'd1) : 32'hFFFF_FFFF;
      nst++;
    end
  endtask

  task automatic run_stream(input int hold, input int vpct, input int rpct, input bit rt);
    int si = 0, oi = 0, opos = 0, cyc = 0, acc = 0;
    bit pstall = 0;
    bit took = 0;
    logic [255:0] pd = '0;
    logic [255:0] ed;
    string tag;
    s_tvalid = 1'b0;
    while (oi < nst && cyc < 20000) begin
      @(negedge clk);
      if (took) begin s_tvalid = 1'b0; took = 0; end
      if (!s_tvalid && si < nst) s_tvalid = ($urandom_range(99) < vpct);
      if (si < nst) begin
        s_tdata = st_d[si]; s_tstrb = st_s[si]; s_tuser = st_u[si]; s_tlast = st_l[si];
      end
      m_tready = (cyc >= hold) && ($urandom_range(99) < rpct);
      #1;
      if (pstall) chk(m_tvalid && (m_tdata == pd), "R8 hold", m_tdata, pd);
      if (hold > 0 && cyc == hold - 1)
        chk(!s_tready && acc == 4, "R9 fill", 256'(acc), 256'd4);
      if (m_tvalid && m_tready) begin
        ed = rt ? org_d[oi] : exp_data(st_d[oi], st_s[oi], opos);
        if (rt) tag = "R7 roundtrip";
        else if (opos == 0) tag = (oi > 0) ? "R6 new frame" : "R1 header";
        else if (opos == 1) tag = "R2 edge";
        else if (st_s[oi] != 32'hFFFF_FFFF) tag = "R4 strobe";
        else tag = "R3 body";
        chk(m_tdata == ed, tag, m_tdata, ed);
        chk(m_tuser == st_u[oi] && m_tstrb == st_s[oi] && m_tlast == st_l[oi],
            "R5 sideband", {m_tlast, m_tstrb, m_tuser}, {st_l[oi], st_s[oi], st_u[oi]});
        cap_d[oi] = m_tdata;
        opos = m_tlast ? 0 : opos + 1;
        oi++;
      end
      pstall = m_tvalid && !m_tready;
      pd = m_tdata;
      if (s_tvalid && s_tready) begin si++; acc++; took = 1; end
      cyc++;
    end
    if (oi < nst) chk(1'b0, "stream stuck", 256'(oi), 256'(nst));
    @(negedge clk);
    s_tvalid = 1'b0;
    m_tready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nvec++; nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; s_tvalid = 1'b0; m_tready = 1'b0;
    s_tdata = '0; s_tstrb = '0; s_tuser = '0; s_tlast = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!m_tvalid && s_tready, "R10 reset", {m_tvalid, s_tready}, 256'b01);
    rst_n = 1'b1;

    // Directed: short frames back to back (R6, R1, R2, R3, R4).
    nst = 0;
    add_pkt(1, 32); add_pkt(2, 20); add_pkt(3, 7); add_pkt(1, 5); add_pkt(4, 32);
    run_stream(0, 100, 100, 0);

    // Directed: stall until the queue fills (R9, R8).
    nst = 0;
    add_pkt(6, 13);
    run_stream(8, 100, 100, 0);

    // Random traffic with throttled handshakes.
    nst = 0;
    for (int p = 0; p < 60; p++) add_pkt(1 + $urandom_range(5), 1 + $urandom_range(31));
    run_stream(0, 70, 60, 0);

    // Round trip: output fed back in restores the payload (R7).
    nst = 0;
    add_pkt(3, 9);
    for (int k = 0; k < nst; k++) org_d[k] = st_d[k];
    run_stream(0, 100, 80, 0);
    for (int k = 0; k < nst; k++) st_d[k] = cap_d[k];
    run_stream(0, 90, 90, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule